// File: doc/BRIEF.md
# Wide-to-Narrow Pipelined Bus Bridge

This block connects a master with a 64-bit pipelined Wishbone port to a 32-bit pipelined Wishbone bus for I/O devices. Each upstream access is turned into one or two downstream accesses, depending on which byte lanes it enables. When lanes are enabled in both 32-bit halves, the bridge sends two downstream beats: the lower word first, then the upper word. When lanes are enabled in only one half, it sends a single beat.

When the last downstream beat is acknowledged, the bridge gives the master a single acknowledge. For reads it returns the 64-bit word built from the beats it collected. Only one upstream access is in flight at any time.

The bridge captures every field needed for the upper beat in the cycle it accepts the upstream request. After that cycle the master may put its next command on the bus without affecting the store that is already in progress.

Top module: `wbsb_bridge`

## Requirements
- R1: While reset is high, and in the first cycle after it, up_stall, up_ack, dn_cyc and dn_stb are all low.
- R2: An upstream request is accepted on a clock edge where up_cyc and up_stb are high and up_stall is low. In the next cycle dn_cyc and dn_stb are high and the first beat is on the downstream bus.
- R3: If up_sel[3:0] and up_sel[7:4] are both nonzero, the first beat is a downstream access with dn_adr = {up_adr,1'b0}, dn_dat_w = up_dat_w[31:0] and dn_sel = up_sel[3:0].
- R4: up_stall is high from the cycle after acceptance through the final downstream acknowledge. It is low in the cycle where up_ack is high, and whenever the bridge is idle.
- R5: The upper beat of a two-beat access is raised only in the cycle after the first beat's dn_ack. It carries dn_adr = {up_adr,1'b1}, dn_dat_w = up_dat_w[63:32] and dn_sel = up_sel[7:4], using the values present at acceptance, even if the master has changed its outputs since. No dn_stb is raised while a downstream acknowledge is outstanding.
- R6: If up_sel[7:4] is zero (this includes an all-zero select), exactly one beat is sent: {up_adr,1'b0}, the lower data and up_sel[3:0].
- R7: If only up_sel[7:4] is nonzero, exactly one beat is sent at {up_adr,1'b1}, carrying up_dat_w[63:32] and up_sel[7:4] on the 32-bit lanes.
- R8: While dn_stb is high and dn_stall is high, dn_stb, dn_adr, dn_dat_w, dn_sel and dn_we do not change.
- R9: up_ack is high for exactly one cycle: the cycle after the final dn_ack. In that same cycle dn_cyc goes low.
- R10: When a read completes, up_dat_r holds the upper-beat data in bits 63:32 and the lower-beat data in bits 31:0. A half that was not fetched reads as zero.
- R11: Write data and we are latched at acceptance whatever the value of we. On every beat, dn_we equals the accepted we, and dn_dat_w carries the accepted half even on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_cyc | input | 1 | Upstream cycle valid |
| up_stb | input | 1 | Upstream request strobe |
| up_we | input | 1 | Upstream write enable |
| up_adr | input | ADR_W | Upstream 64-bit word address |
| up_dat_w | input | 2*DN_DW | Upstream write data |
| up_sel | input | 2*DN_DW/8 | Upstream byte lane enables |
| up_stall | output | 1 | Upstream back-pressure |
| up_ack | output | 1 | Upstream completion pulse |
| up_dat_r | output | 2*DN_DW | Upstream read data |
| dn_cyc | output | 1 | Downstream cycle valid |
| dn_stb | output | 1 | Downstream request strobe |
| dn_we | output | 1 | Downstream write enable |
| dn_adr | output | ADR_W+1 | Downstream 32-bit word address |
| dn_dat_w | output | DN_DW | Downstream write data |
| dn_sel | output | DN_DW/8 | Downstream byte lane enables |
| dn_stall | input | 1 | Downstream back-pressure |
| dn_ack | input | 1 | Downstream completion |
| dn_dat_r | input | DN_DW | Downstream read data |

## Verification
If the capture registers reload or go stale, the fault shows up on the upper beat. That beat appears one cycle after the first downstream acknowledge, and its address, data or lane enables would then differ from the values accepted at the start. If the sequencer loses track of the beat count, the result is visible within a few cycles: an extra or missing dn_stb, up_ack arriving too early or too late, or up_stall falling before the acknowledge. If the read halves are misplaced, up_dat_r is wrong in the very cycle up_ack is high.

// File: rtl/wbsb_pkg.sv
package wbsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } wbsb_state_e;

  typedef enum logic [1:0] {
    PLAN_LO   = 2'd0,
    PLAN_HI   = 2'd1,
    PLAN_BOTH = 2'd2
  } wbsb_plan_e;
endpackage

// File: rtl/wbsb_plan.sv
module wbsb_plan
  import wbsb_pkg::*;
#(
  parameter int DN_SW = 4
) (
  input  logic [2*DN_SW-1:0] sel,
  output wbsb_plan_e         plan
);
  logic [1:0] half_any;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half_any[h] = |sel[h*DN_SW +: DN_SW];
  end

  always_comb begin
    if (half_any[0] && half_any[1]) plan = PLAN_BOTH;
    else if (half_any[1])           plan = PLAN_HI;
    else                            plan = PLAN_LO;
  end
endmodule

// File: rtl/wbsb_capture.sv
module wbsb_capture #(
  parameter int ADR_W = 29,
  parameter int DN_DW = 32,
  localparam int UP_DW = 2 * DN_DW,
  localparam int UP_SW = UP_DW / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             we_in,
  input  logic [ADR_W-1:0] adr_in,
  input  logic [UP_DW-1:0] dat_in,
  input  logic [UP_SW-1:0] sel_in,
  output logic             we_q,
  output logic [ADR_W-1:0] adr_q,
  output logic [UP_DW-1:0] dat_q,
  output logic [UP_SW-1:0] sel_q
);
  // Everything is taken in the acceptance cycle; data regardless of we.
  always_ff @(posedge clk) begin
    if (rst) begin
      we_q  <= 1'b0;
      adr_q <= '0;
      dat_q <= '0;
      sel_q <= '0;
    end else if (load) begin
      we_q  <= we_in;
      adr_q <= adr_in;
      dat_q <= dat_in;
      sel_q <= sel_in;
    end
  end
endmodule

// File: rtl/wbsb_seq.sv
module wbsb_seq
  import wbsb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       up_cyc,
  input  logic       up_stb,
  input  wbsb_plan_e plan_now,
  input  logic       dn_stall,
  input  logic       dn_ack,
  output logic       accept,
  output logic       take,
  output logic       beat_hi,
  output logic       up_stall,
  output logic       up_ack,
  output logic       dn_cyc,
  output logic       dn_stb
);
  wbsb_state_e state;
  logic        two_beats;

  assign accept = up_cyc && up_stb && !up_stall;
  assign take   = (state == ST_WAIT) && dn_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      two_beats <= 1'b0;
      beat_hi   <= 1'b0;
      up_stall  <= 1'b0;
      up_ack    <= 1'b0;
      dn_cyc    <= 1'b0;
      dn_stb    <= 1'b0;
    end else begin
      up_ack <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state     <= ST_REQ;
          dn_cyc    <= 1'b1;
          dn_stb    <= 1'b1;
          up_stall  <= 1'b1;
          beat_hi   <= (plan_now == PLAN_HI);
          two_beats <= (plan_now == PLAN_BOTH);
        end
        ST_REQ: if (!dn_stall) begin
          dn_stb <= 1'b0;
          state  <= ST_WAIT;
        end
        ST_WAIT: if (dn_ack) begin
          if (two_beats && !beat_hi) begin
            beat_hi <= 1'b1;
            dn_stb  <= 1'b1;
            state   <= ST_REQ;
          end else begin
            state    <= ST_IDLE;
            dn_cyc   <= 1'b0;
            up_stall <= 1'b0;
            up_ack   <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_STALL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (up_cyc && up_stb && !up_stall) |=> up_stall); // R4
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    up_ack |=> !up_ack); // R9
  AST_STB_IN_CYC: assert property (@(posedge clk) disable iff (rst)
    dn_stb |-> dn_cyc); // R2
  AST_UPPER_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    ($rose(dn_stb) && $past(dn_cyc)) |-> $past(dn_ack)); // R5
endmodule

// File: rtl/wbsb_rdasm.sv
module wbsb_rdasm #(
  parameter int DN_DW = 32,
  localparam int UP_DW = 2 * DN_DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             take,
  input  logic             beat_hi,
  input  logic [DN_DW-1:0] dn_dat_r,
  output logic [UP_DW-1:0] up_dat_r
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst || start)
        up_dat_r[h*DN_DW +: DN_DW] <= '0;
      else if (take && (beat_hi == 1'(h)))
        up_dat_r[h*DN_DW +: DN_DW] <= dn_dat_r;
    end
  end
endmodule

// File: rtl/wbsb_bridge.sv
module wbsb_bridge
  import wbsb_pkg::*;
#(
  parameter int ADR_W = 29,
  parameter int DN_DW = 32,
  localparam int UP_DW = 2 * DN_DW,
  localparam int DN_SW = DN_DW / 8,
  localparam int UP_SW = 2 * DN_SW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_cyc,
  input  logic             up_stb,
  input  logic             up_we,
  input  logic [ADR_W-1:0] up_adr,
  input  logic [UP_DW-1:0] up_dat_w,
  input  logic [UP_SW-1:0] up_sel,
  output logic             up_stall,
  output logic             up_ack,
  output logic [UP_DW-1:0] up_dat_r,
  output logic             dn_cyc,
  output logic             dn_stb,
  output logic             dn_we,
  output logic [ADR_W:0]   dn_adr,
  output logic [DN_DW-1:0] dn_dat_w,
  output logic [DN_SW-1:0] dn_sel,
  input  logic             dn_stall,
  input  logic             dn_ack,
  input  logic [DN_DW-1:0] dn_dat_r
);
  wbsb_plan_e       plan_now;
  logic             accept, take, beat_hi;
  logic             we_q;
  logic [ADR_W-1:0] adr_q;
  logic [UP_DW-1:0] dat_q;
  logic [UP_SW-1:0] sel_q;

  wbsb_plan #(.DN_SW(DN_SW)) u_plan (.sel(up_sel), .plan(plan_now));

  wbsb_capture #(.ADR_W(ADR_W), .DN_DW(DN_DW)) u_cap (
    .clk(clk), .rst(rst), .load(accept),
    .we_in(up_we), .adr_in(up_adr), .dat_in(up_dat_w), .sel_in(up_sel),
    .we_q(we_q), .adr_q(adr_q), .dat_q(dat_q), .sel_q(sel_q)
  );

  wbsb_seq u_seq (
    .clk(clk), .rst(rst), .up_cyc(up_cyc), .up_stb(up_stb),
    .plan_now(plan_now), .dn_stall(dn_stall), .dn_ack(dn_ack),
    .accept(accept), .take(take), .beat_hi(beat_hi),
    .up_stall(up_stall), .up_ack(up_ack), .dn_cyc(dn_cyc), .dn_stb(dn_stb)
  );

  wbsb_rdasm #(.DN_DW(DN_DW)) u_rd (
    .clk(clk), .rst(rst), .start(accept), .take(take), .beat_hi(beat_hi),
    .dn_dat_r(dn_dat_r), .up_dat_r(up_dat_r)
  );

  // Downstream beat fields come only from captured state.
  assign dn_we    = we_q;
  assign dn_adr   = {adr_q, beat_hi};
  assign dn_dat_w = beat_hi ? dat_q[UP_DW-1:DN_DW] : dat_q[DN_DW-1:0];
  assign dn_sel   = beat_hi ? sel_q[UP_SW-1:DN_SW] : sel_q[DN_SW-1:0];

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    (dn_stb && dn_stall) |=> (dn_stb && $stable(dn_adr) && $stable(dn_dat_w)
                              && $stable(dn_sel) && $stable(dn_we))); // R8
  AST_ACK_ENDS_CYCLE: assert property (@(posedge clk) disable iff (rst)
    up_ack |-> (!dn_cyc && !dn_stb)); // R9
endmodule

// File: tb/sim_wbsb_bridge.sv
module sim_wbsb_bridge;
  localparam int AW = 29, DW = 32, UW = 64, SW = 4, USW = 8;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic up_cyc = 0, up_stb = 0, up_we = 0;
  logic [AW-1:0] up_adr = '0;
  logic [UW-1:0] up_dat_w = '0;
  logic [USW-1:0] up_sel = '0;
  logic up_stall, up_ack;
  logic [UW-1:0] up_dat_r;
  logic dn_cyc, dn_stb, dn_we;
  logic [AW:0] dn_adr;
  logic [DW-1:0] dn_dat_w;
  logic [SW-1:0] dn_sel;
  logic dn_stall = 0, dn_ack = 0;
  logic [DW-1:0] dn_dat_r = '0;

  wbsb_bridge #(.ADR_W(AW), .DN_DW(DW)) u0 (.*);

  typedef struct packed {
    logic [AW:0] adr; logic [DW-1:0] dat; logic [SW-1:0] sel; logic we; logic [1:0] kind;
  } beat_t;
  typedef struct packed {
    logic we; logic [AW-1:0] adr; logic [UW-1:0] dat; logic [USW-1:0] sel;
  } txn_t;

  beat_t bq[$];
  beat_t aq[$];
  txn_t  txq[$];
  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string kind_tag(input logic [1:0] k);
    case (k)
      2'd0: return "R3";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    bit m_cyc, m_stb, m_stall, m_ack, m_read, prev_stall, accepted_last, presenting, pending;
    logic [63:0] m_rd;
    int ack_wait, gap, cyc;
    txn_t t;
    beat_t b;
    m_cyc = 0; m_stb = 0; m_stall = 0; m_ack = 0; m_read = 0; prev_stall = 0;
    accepted_last = 0; presenting = 0; pending = 0; m_rd = '0;
    ack_wait = 0; gap = 0; cyc = 0;

    txq.push_back('{1'b1, 29'd5, 64'h1111_2222_3333_4444, 8'hFF});
    txq.push_back('{1'b1, 29'd6, 64'h5555_6666_7777_8888, 8'h0F});
    txq.push_back('{1'b1, 29'd7, 64'h9999_AAAA_BBBB_CCCC, 8'hF0});
    txq.push_back('{1'b1, 29'd8, 64'hDEAD_BEEF_0BAD_F00D, 8'h00});
    txq.push_back('{1'b0, 29'd9, 64'hCAFE_0001_CAFE_0002, 8'hFF});
    txq.push_back('{1'b0, 29'd10, 64'h0, 8'h0C});
    txq.push_back('{1'b0, 29'd11, 64'h0, 8'h30});
    txq.push_back('{1'b1, 29'd12, 64'h0123_4567_89AB_CDEF, 8'h81});
    for (int i = 0; i < 160; i++) begin
      t.we = 1'($urandom);
      t.adr = AW'($urandom);
      t.dat = {$urandom, $urandom};
      t.sel = 8'($urandom);
      txq.push_back(t);
    end

    repeat (3) @(negedge clk);
    chk(!up_stall && !up_ack && !dn_cyc && !dn_stb, "R1", "outputs in reset",
        {up_stall, up_ack, dn_cyc, dn_stb}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!up_stall && !up_ack && !dn_cyc && !dn_stb, "R1", "outputs after reset",
        {up_stall, up_ack, dn_cyc, dn_stb}, 64'h0);

    while (cyc < 100000 && (txq.size() > 0 || presenting || m_cyc || m_ack)) begin
      cyc++;
      // Outputs of this cycle against the reference
      chk(dn_stb == m_stb, "R2", "dn_stb", dn_stb, m_stb);
      chk(dn_cyc == m_cyc, "R9", "dn_cyc", dn_cyc, m_cyc);
      chk(up_stall == m_stall, "R4", "up_stall", up_stall, m_stall);
      chk(up_ack == m_ack, "R9", "up_ack", up_ack, m_ack);
      chk(!(dn_stb && pending), "R5", "stb with ack outstanding", dn_stb, 0);
      if (m_stb && dn_stb && bq.size() > 0) begin
        b = bq[0];
        chk(dn_adr == b.adr, prev_stall ? "R8" : kind_tag(b.kind), "dn_adr", dn_adr, b.adr);
        chk(dn_sel == b.sel, prev_stall ? "R8" : kind_tag(b.kind), "dn_sel", dn_sel, b.sel);
        chk(dn_dat_w == b.dat, prev_stall ? "R8" : (b.we ? kind_tag(b.kind) : "R11"),
            "dn_dat_w", dn_dat_w, b.dat);
        chk(dn_we == b.we, "R11", "dn_we", dn_we, b.we);
      end
      if (m_ack && up_ack && m_read)
        chk(up_dat_r == m_rd, "R10", "up_dat_r", up_dat_r, m_rd);

      // Drive inputs for the coming edge
      dn_ack = (ack_wait == 1);
      if (dn_ack) dn_dat_r = $urandom;
      if (ack_wait > 0) ack_wait--;
      dn_stall = ($urandom_range(0, 3) == 0);
      if (accepted_last) begin
        up_dat_w = ~up_dat_w; up_sel = ~up_sel; up_adr = ~up_adr; up_we = ~up_we;
        up_stb = 1'b0; up_cyc = 1'b0; presenting = 0;
        gap = $urandom_range(0, 2);
      end
      if (!presenting) begin
        if (gap > 0) gap--;
        else if (txq.size() > 0) begin
          t = txq.pop_front();
          up_cyc = 1'b1; up_stb = 1'b1; up_we = t.we;
          up_adr = t.adr; up_dat_w = t.dat; up_sel = t.sel;
          presenting = 1;
        end
      end

      // Reference update for the coming edge
      prev_stall = dn_stb && dn_stall;
      m_ack = 0;
      accepted_last = 0;
      if (dn_ack && pending) begin
        b = aq.pop_front();
        pending = 0;
        if (b.adr[0]) m_rd[63:32] = dn_dat_r; else m_rd[31:0] = dn_dat_r;
        if (bq.size() > 0) m_stb = 1;
        else begin m_ack = 1; m_cyc = 0; m_stall = 0; end
      end else if (dn_stb && !dn_stall && bq.size() > 0) begin
        aq.push_back(bq.pop_front());
        m_stb = 0; pending = 1;
        ack_wait = $urandom_range(1, 3);
      end
      if (up_cyc && up_stb && !up_stall) begin
        accepted_last = 1;
        m_cyc = 1; m_stb = 1; m_stall = 1; m_read = !up_we; m_rd = '0;
        if (|up_sel[3:0] && |up_sel[7:4]) begin
          bq.push_back('{{up_adr, 1'b0}, up_dat_w[31:0], up_sel[3:0], up_we, 2'd0});
          bq.push_back('{{up_adr, 1'b1}, up_dat_w[63:32], up_sel[7:4], up_we, 2'd1});
        end else if (|up_sel[7:4])
          bq.push_back('{{up_adr, 1'b1}, up_dat_w[63:32], up_sel[7:4], up_we, 2'd3});
        else
          bq.push_back('{{up_adr, 1'b0}, up_dat_w[31:0], up_sel[3:0], up_we, 2'd2});
      end
      @(negedge clk);
    end

    if (cyc >= 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not drain, actual=%0d expected<%0d", cyc, 100000);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule